// File: doc/BRIEF.md
# Interrupt Pending Clear/Post Register

This block holds the pending state of six interrupt sources: a USB wake event and five USB endpoint events. A one-cycle event pulse from a source sets the pending bit for that source. The six pending bits go straight to the interrupt controller as a request vector. A simple CPU bus can read the pending state back at one register address. Writes to that address either clear or post pending bits. Which of the two a write does depends on a global software-interrupt enable input.

When the enable is low, a written 0 clears the matching bit and a written 1 does nothing. When the enable is high, a written 1 posts (sets) the matching bit and a written 0 does nothing. The two upper bits of the 8-bit register are reserved. Writes to them have no effect and they always read as zero. A hardware event always wins over a software clear in the same cycle, so no event is lost.

Top module: `irq_clr_post_reg`

## Requirements
- R1: After a synchronous reset, all six pending bits are 0 and the read data is 0x00.
- R2: A read strobe with a matching address returns {2'b00, pending} on `bus_rdata` in the following cycle. A read at any other address returns 0x00.
- R3: A write with the software enable low clears each pending bit whose write-data bit is 0.
- R4: A write with the software enable low leaves each pending bit whose write-data bit is 1 unchanged.
- R5: A write with the software enable high leaves each pending bit whose write-data bit is 0 unchanged.
- R6: A write with the software enable high sets each pending bit whose write-data bit is 1.
- R7: Write-data bits 7 and 6 are ignored, and read-data bits 7 and 6 are always 0.
- R8: A high level on `evt_in[i]` sets pending bit i at the next clock edge, whatever the bus is doing.
- R9: When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: A write changes nothing unless `bus_wr` is high and `bus_addr` equals the register address (default 0xDC).
- R11: Bit positions are fixed: bit 5 is USB wake, bit 4 is endpoint 8, and bits 3..0 are endpoints 7, 6, 5 and 4. `evt_in` and `irq_pend` use the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| swint_en | input | 1 | Global software-interrupt enable (selects post mode) |
| evt_in | input | 6 | Hardware event pulses, one per source |
| irq_pend | output | 6 | Pending request vector to the interrupt controller |

## Verification
The assertions assume that `evt_in`, `swint_en` and the bus strobes are stable, known values at each rising edge. They also assume reset is held from time zero until the first edge. The bench meets these assumptions by driving every input on the falling edge and asserting reset before the clock starts. The bench combines events with clearing and posting writes in the same cycle, and it sends writes to a non-matching address. This exercises every antecedent of the per-bit properties, including the case where a set and a clear collide.

// File: rtl/irq_clr_pkg.sv
package irq_clr_pkg;
  localparam int NUM_SRC = 6;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;

  // Source positions in the pending vector
  localparam int SRC_EP4  = 0;
  localparam int SRC_EP5  = 1;
  localparam int SRC_EP6  = 2;
  localparam int SRC_EP7  = 3;
  localparam int SRC_EP8  = 4;
  localparam int SRC_WAKE = 5;

  typedef enum logic [1:0] {
    WOP_NONE  = 2'd0,
    WOP_CLEAR = 2'd1,
    WOP_POST  = 2'd2
  } wr_op_e;
endpackage

// File: rtl/irq_addr_match.sv
module irq_addr_match #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'hDC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              swen,
  output logic              wr_hit,
  output logic              rd_hit,
  output irq_clr_pkg::wr_op_e op
);
  logic match;
  assign match  = (addr == ADDR_W'(REG_ADDR));
  assign wr_hit = wr & match;
  assign rd_hit = rd & match;

  always_comb begin
    if (!wr_hit)   op = irq_clr_pkg::WOP_NONE;
    else if (swen) op = irq_clr_pkg::WOP_POST;
    else           op = irq_clr_pkg::WOP_CLEAR;
  end
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt,
  input  irq_clr_pkg::wr_op_e op,
  input  logic                wbit,
  output logic                pend
);
  logic nxt;

  always_comb begin
    nxt = pend;
    if (op == irq_clr_pkg::WOP_CLEAR && !wbit) nxt = 1'b0;
    if (op == irq_clr_pkg::WOP_POST  &&  wbit) nxt = 1'b1;
    if (evt) nxt = 1'b1; // hardware event has priority
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= nxt;
  end

  p_evt_sets_r8: assert property (@(posedge clk) disable iff (rst)
    evt |=> pend);
  p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (evt && op == irq_clr_pkg::WOP_CLEAR && !wbit) |=> pend);
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!evt && op == irq_clr_pkg::WOP_CLEAR && !wbit) |=> !pend);
  p_post_r6: assert property (@(posedge clk) disable iff (rst)
    (op == irq_clr_pkg::WOP_POST && wbit) |=> pend);
  p_clear_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!evt && op == irq_clr_pkg::WOP_CLEAR && wbit) |=> $stable(pend));
  p_post_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!evt && op == irq_clr_pkg::WOP_POST && !wbit) |=> $stable(pend));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!evt && op == irq_clr_pkg::WOP_NONE) |=> $stable(pend));
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_hit,
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  rdata
);
  localparam int RSVD_W = DATA_W - NUM_SRC;

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= {{RSVD_W{1'b0}}, pend};
    else             rdata <= '0;
  end

  always @(posedge clk) begin
    if (!rst) p_rsvd_zero_r7: assert (rdata[DATA_W-1:NUM_SRC] == '0);
  end

  p_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rdata[NUM_SRC-1:0] == $past(pend));
  p_read_miss_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> rdata == '0);
endmodule

// File: rtl/irq_clr_post_reg.sv
module irq_clr_post_reg #(
  parameter int         NUM_SRC  = irq_clr_pkg::NUM_SRC,
  parameter int         DATA_W   = irq_clr_pkg::DATA_W,
  parameter int         ADDR_W   = irq_clr_pkg::ADDR_W,
  parameter logic [7:0] REG_ADDR = 8'hDC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               swint_en,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic [NUM_SRC-1:0] irq_pend
);
  logic                wr_hit, rd_hit;
  irq_clr_pkg::wr_op_e op;

  irq_addr_match #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .swen(swint_en),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .op(op)
  );

  // Only the defined bit positions feed a cell; reserved write bits are dropped (R7)
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    irq_pend_cell u_cell (
      .clk(clk), .rst(rst), .evt(evt_in[i]), .op(op),
      .wbit(bus_wdata[i]), .pend(irq_pend[i])
    );
  end

  irq_rd_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .pend(irq_pend), .rdata(bus_rdata)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (irq_pend == '0 && bus_rdata == '0));
  p_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && evt_in == '0) |=> $stable(irq_pend));
endmodule

// File: tb/irq_clr_post_reg_tb_top.sv
module irq_clr_post_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, swint_en = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [5:0] evt_in = 6'h00;
  logic [5:0] irq_pend;
  int tests = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  irq_clr_post_reg dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .swint_en(swint_en),
    .evt_in(evt_in), .irq_pend(irq_pend)
  );

  // {evt[5:0], wr, sw, hit, wdata[7:0], exp_pend[5:0], req[3:0]}
  localparam logic [26:0] VEC [12] = '{
    {6'b010101, 1'b0, 1'b0, 1'b1, 8'h00, 6'b010101, 4'd8 },  // R8
    {6'b000000, 1'b1, 1'b0, 1'b1, 8'h3F, 6'b010101, 4'd4 },  // R4
    {6'b000000, 1'b1, 1'b0, 1'b1, 8'hFE, 6'b010100, 4'd3 },  // R3
    {6'b000000, 1'b1, 1'b1, 1'b1, 8'h00, 6'b010100, 4'd5 },  // R5
    {6'b000000, 1'b1, 1'b1, 1'b1, 8'h0A, 6'b011110, 4'd6 },  // R6
    {6'b000000, 1'b1, 1'b0, 1'b0, 8'h00, 6'b011110, 4'd10},  // R10
    {6'b000010, 1'b1, 1'b0, 1'b1, 8'h00, 6'b000010, 4'd9 },  // R9
    {6'b100000, 1'b1, 1'b1, 1'b1, 8'hC1, 6'b100011, 4'd7 },  // R7
    {6'b000000, 1'b1, 1'b0, 1'b1, 8'h1F, 6'b000011, 4'd11},  // R11
    {6'b000000, 1'b0, 1'b1, 1'b1, 8'hFF, 6'b000011, 4'd10},  // R10
    {6'b000000, 1'b1, 1'b1, 1'b0, 8'hFF, 6'b000011, 4'd10},  // R10
    {6'b000000, 1'b1, 1'b0, 1'b1, 8'hC0, 6'b000000, 4'd3 }   // R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; evt_in = '0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); idle(); bus_rd = 1; bus_addr = a;
    @(negedge clk); d = bus_rdata; idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R1 pend", {2'b00, irq_pend}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rst = 0;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      evt_in = VEC[i][26:21]; bus_wr = VEC[i][20]; swint_en = VEC[i][19];
      bus_addr = VEC[i][18] ? 8'hDC : 8'hDD; bus_wdata = VEC[i][17:10];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), {2'b00, irq_pend}, {2'b00, VEC[i][9:4]});
      idle(); swint_en = 0;
    end

    // R11: wake event lands in bit 5; endpoint 4 in bit 0
    @(negedge clk); evt_in = 6'b100000;
    @(negedge clk); idle();
    check("R11 wake bit", {2'b00, irq_pend}, 8'h20);
    // R2: read back at matching address, R7 reserved zero
    do_read(8'hDC, rd);
    check("R2 read hit", rd, 8'h20);
    check("R7 rsvd read", rd & 8'hC0, 8'h00);
    do_read(8'h5C, rd);
    check("R2 read miss", rd, 8'h00);
    // R7: posting to reserved bits only has no effect, read shows it
    @(negedge clk); bus_wr = 1; swint_en = 1; bus_addr = 8'hDC; bus_wdata = 8'hC0;
    @(negedge clk); idle(); swint_en = 0;
    do_read(8'hDC, rd);
    check("R7 rsvd write", rd, 8'h20);
    // R11: endpoint 4 event
    @(negedge clk); evt_in = 6'b000001;
    @(negedge clk); idle();
    check("R11 ep4 bit", {2'b00, irq_pend}, 8'h21);
    // R1: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 re-reset", {2'b00, irq_pend}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule